// File: doc/BRIEF.md
# Multi-Mode Serial Clock Generator

This block makes the timing strobes for a serial transmitter and receiver that share one set of mode controls. A programmable down-counter produces a base tick. From that tick the block derives the bit strobes for one of four operating modes: normal asynchronous, double-speed asynchronous, synchronous master and synchronous slave. In master mode the block drives a transfer clock out on a pin. In slave mode it takes that clock from the pin, passes it through a synchroniser and turns its edges into single-cycle strobes.

The shift registers and framing logic sit downstream and consume four strobes:
- `rx_tick`: the receiver's sample or oversample strobe.
- `tx_tick`: the transmitter's bit-advance strobe.
- `samp_rise`, `samp_fall`: edge strobes that are active only in the synchronous modes.

Changing the mode restarts all internal counting. The first strobe after a change therefore comes a full period later.

Top module: `serial_clkgen`

## Requirements
- R1: With divisor value D on `baud_div`, the base tick repeats every D+1 clock cycles. In both asynchronous modes `rx_tick` is the base tick.
- R2: In normal asynchronous mode (`sync_en`=0, `fast_en`=0), `tx_tick` fires once per 16 base ticks, on the 16th base tick after a restart and every 16 after that.
- R3: In double-speed asynchronous mode (`sync_en`=0, `fast_en`=1), `tx_tick` fires once per 8 base ticks.
- R4: While `sync_en`=1, `fast_en` has no effect. Toggling it neither changes nor restarts any strobe or the transfer clock.
- R5: In master mode (`sync_en`=1, `xclk_dir_out`=1):
  - `xclk_oe` is 1.
  - `xclk_out` starts low after a restart and toggles after every base tick.
  - `samp_rise` and `rx_tick` pulse in the cycle whose closing edge raises `xclk_out`.
  - `samp_fall` and `tx_tick` pulse in the cycle whose closing edge lowers `xclk_out`.
- R6: In slave mode (`sync_en`=1, `xclk_dir_out`=0):
  - `xclk_oe` and `xclk_out` stay 0.
  - A rising edge on `xclk_in` produces a one-cycle `samp_rise`/`rx_tick` pulse two cycles after the input changes.
  - A falling edge produces a one-cycle `samp_fall`/`tx_tick` pulse with the same delay.
- R7: In asynchronous mode, `xclk_oe`, `xclk_out`, `samp_rise` and `samp_fall` stay 0. Activity on `xclk_in` and changes to `xclk_dir_out` have no effect.
- R8: A change of effective mode restarts the divisor counter, the bit prescaler and the transfer clock. The first base tick then arrives D+1 cycles after the change, and no strobe fires in the cycle of the change.
- R9: While `rst_n` is low, all four strobes and `xclk_out` are 0. Leaving reset acts as a restart (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | DIV_W | Divisor value D; base period is D+1 cycles |
| sync_en | input | 1 | 0 selects asynchronous operation, 1 selects synchronous operation |
| fast_en | input | 1 | Double-speed select, used in asynchronous mode only |
| xclk_dir_out | input | 1 | Transfer-clock pin direction: 1 selects master, 0 selects slave |
| xclk_in | input | 1 | External transfer clock; must be slower than a quarter of `clk` |
| xclk_out | output | 1 | Generated transfer clock (master mode) |
| xclk_oe | output | 1 | Output enable for the transfer-clock pin |
| tx_tick | output | 1 | Transmit bit strobe |
| rx_tick | output | 1 | Receive sample or oversample strobe |
| samp_rise | output | 1 | Transfer-clock rising-edge strobe (synchronous modes) |
| samp_fall | output | 1 | Transfer-clock falling-edge strobe (synchronous modes) |

## Verification
The bench sweeps small divisor values through every mode and checks the exact cycle of each strobe.

- Divisor of zero: a counter that mishandles it would stall, or would tick every other cycle instead of every cycle.
- Mode changes: each one is followed by a check of where the first strobe lands. A design that does not restart would deliver a short first period.
- Synchronous operation: the double-speed bit is flipped mid-run. A design that let it leak into the mode decode would restart and shift every later strobe.
- Asynchronous operation: the external clock is toggled and the pin direction is flipped. A design that failed to mask the pin would show spurious edge strobes or a driven output.
- Slave mode: external clocks of two different periods are applied. A wrong synchroniser depth would move every edge strobe by a cycle.

// File: rtl/clkgen_pkg.sv
// Shared types for the serial clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package clkgen_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC_NORM  = 2'd0,
        MODE_ASYNC_FAST  = 2'd1,
        MODE_SYNC_MASTER = 2'd2,
        MODE_SYNC_SLAVE  = 2'd3
    } clk_mode_e;

    // Collapse the three mode pins into the effective mode; ignored pins drop out here.
    function automatic clk_mode_e pick_mode(input logic sync_en,
                                            input logic fast_en,
                                            input logic dir_out);
        if (sync_en)
            return dir_out ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
        return fast_en ? MODE_ASYNC_FAST : MODE_ASYNC_NORM;
    endfunction

endpackage

// File: rtl/clkgen_baud_counter.sv
// Programmable down-counter producing the base tick.
// Counts from baud_div down to zero; at zero emits base_tick and reloads.
// Assumes: restart is a one-cycle request from the parent and forces a reload.
module clkgen_baud_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] baud_div,
    output logic             base_tick
);

    logic [DIV_W-1:0] cnt_q;

    // Count down, reload on zero, reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= baud_div;
        else if (cnt_q == '0)
            cnt_q <= baud_div;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // Base tick while the count sits at zero, suppressed on a restart cycle.
    always_comb begin
        base_tick = (cnt_q == '0) && !restart;
    end

    AST_RELOAD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> cnt_q == $past(baud_div)) else $error("reload missed"); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1) else $error("count step"); // R1

endmodule

// File: rtl/clkgen_async_div.sv
// Bit prescaler for the asynchronous modes: divides base ticks by NORM_RATIO
// or, in double speed, by FAST_RATIO, emitting bit_tick on the last base tick.
// Assumes: FAST_RATIO <= NORM_RATIO, both at least 2.
module clkgen_async_div #(
    parameter int NORM_RATIO = 16,
    parameter int FAST_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic base_tick,
    input  logic fast,
    output logic bit_tick
);

    localparam int PW = $clog2(NORM_RATIO);
    localparam logic [PW-1:0] NORM_LAST = PW'(NORM_RATIO - 1);
    localparam logic [PW-1:0] FAST_LAST = PW'(FAST_RATIO - 1);

    logic [PW-1:0] presc_q;
    logic [PW-1:0] last;

    // Select the terminal count for the active speed.
    always_comb begin
        last     = fast ? FAST_LAST : NORM_LAST;
        bit_tick = base_tick && (presc_q == last);
    end

    // Advance the prescaler on each base tick, wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            presc_q <= '0;
        else if (base_tick)
            presc_q <= (presc_q == last) ? '0 : presc_q + 1'b1;
    end

    AST_WRAP_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> presc_q == '0) else $error("no wrap"); // R2

    AST_PRESC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && !bit_tick && !restart) |=> presc_q == $past(presc_q) + 1'b1) else $error("presc step"); // R3

endmodule

// File: rtl/clkgen_master_sync.sv
// Master transfer-clock generator: toggles xck on every base tick and flags
// the cycle before each rising and falling transition.
// Assumes: restart forces xck low so the first half period is full length.
module clkgen_master_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic base_tick,
    output logic xck,
    output logic rise_stb,
    output logic fall_stb
);

    logic xck_q;

    // Toggle the transfer clock on each base tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            xck_q <= 1'b0;
        else if (base_tick)
            xck_q <= ~xck_q;
    end

    // Announce the coming transition one cycle ahead.
    always_comb begin
        xck      = xck_q;
        rise_stb = base_tick && !xck_q;
        fall_stb = base_tick &&  xck_q;
    end

    AST_XCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && !restart) |=> xck_q != $past(xck_q)) else $error("no toggle"); // R5

    AST_XCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_tick && !restart) |=> $stable(xck_q)) else $error("xck moved"); // R5

endmodule

// File: rtl/clkgen_slave_sync.sv
// Slave input path: a SYNC_STAGES flop synchroniser on the external clock,
// then an edge detector producing single-cycle rise and fall strobes.
// Assumes: ext_in is asynchronous and slower than a quarter of clk.
module clkgen_slave_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise_stb,
    output logic fall_stb
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            // One synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sync_q[g] <= 1'b0;
                else if (g == 0)
                    sync_q[g] <= ext_in;
                else
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Hold the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Edge strobes from the synchronised level.
    always_comb begin
        rise_stb =  sync_q[SYNC_STAGES-1] && !prev_q;
        fall_stb = !sync_q[SYNC_STAGES-1] &&  prev_q;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb) else $error("long rise"); // R6

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb) else $error("long fall"); // R6

endmodule

// File: rtl/serial_clkgen.sv
// Top of the multi-mode serial clock generator. Decodes the effective mode,
// restarts all counting on reset exit or any mode change, and routes the
// strobes of the active mode to the outputs.
// Assumes: mode pins are synchronous to clk; xclk_in may be asynchronous.
module serial_clkgen #(
    parameter int DIV_W       = 8,
    parameter int NORM_RATIO  = 16,
    parameter int FAST_RATIO  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             sync_en,
    input  logic             fast_en,
    input  logic             xclk_dir_out,
    input  logic             xclk_in,
    output logic             xclk_out,
    output logic             xclk_oe,
    output logic             tx_tick,
    output logic             rx_tick,
    output logic             samp_rise,
    output logic             samp_fall
);
    import clkgen_pkg::*;

    clk_mode_e mode, mode_q;
    logic      active_q;
    logic      restart;
    logic      base_tick, bit_tick;
    logic      m_xck, m_rise, m_fall;
    logic      s_rise, s_fall;

    // Effective mode and restart request.
    always_comb begin
        mode    = pick_mode(sync_en, fast_en, xclk_dir_out);
        restart = !active_q || (mode != mode_q);
    end

    // Remember the mode and whether reset has been left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            mode_q   <= MODE_ASYNC_NORM;
        end else begin
            active_q <= 1'b1;
            mode_q   <= mode;
        end
    end

    clkgen_baud_counter #(.DIV_W(DIV_W)) i_baud (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .baud_div(baud_div), .base_tick(base_tick)
    );

    clkgen_async_div #(.NORM_RATIO(NORM_RATIO), .FAST_RATIO(FAST_RATIO)) i_adiv (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .base_tick(base_tick), .fast(mode == MODE_ASYNC_FAST), .bit_tick(bit_tick)
    );

    clkgen_master_sync i_msync (
        .clk(clk), .rst_n(rst_n), .restart(restart), .base_tick(base_tick),
        .xck(m_xck), .rise_stb(m_rise), .fall_stb(m_fall)
    );

    clkgen_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) i_ssync (
        .clk(clk), .rst_n(rst_n), .ext_in(xclk_in),
        .rise_stb(s_rise), .fall_stb(s_fall)
    );

    // Route the active mode's strobes; silence everything on restart.
    always_comb begin
        xclk_out  = 1'b0;
        xclk_oe   = 1'b0;
        tx_tick   = 1'b0;
        rx_tick   = 1'b0;
        samp_rise = 1'b0;
        samp_fall = 1'b0;
        case (mode)
            MODE_ASYNC_NORM, MODE_ASYNC_FAST: begin
                rx_tick = base_tick;
                tx_tick = bit_tick;
            end
            MODE_SYNC_MASTER: begin
                xclk_oe   = 1'b1;
                xclk_out  = m_xck && !restart;
                rx_tick   = m_rise;
                tx_tick   = m_fall;
                samp_rise = m_rise;
                samp_fall = m_fall;
            end
            default: begin
                rx_tick   = s_rise;
                tx_tick   = s_fall;
                samp_rise = s_rise;
                samp_fall = s_fall;
            end
        endcase
        if (restart) begin
            tx_tick   = 1'b0;
            rx_tick   = 1'b0;
            samp_rise = 1'b0;
            samp_fall = 1'b0;
        end
    end

    AST_ASYNC_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> (!xclk_oe && !xclk_out && !samp_rise && !samp_fall)) else $error("pin active"); // R7

    AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !xclk_dir_out) |-> (!xclk_oe && !xclk_out)) else $error("slave drives"); // R6

    AST_RESTART_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !(tx_tick || rx_tick || samp_rise || samp_fall)) else $error("strobe on restart"); // R8

    AST_SYNC_EDGE_SEP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en |-> !(samp_rise && samp_fall)) else $error("both edges"); // R5

endmodule

// File: tb/test_serial_clkgen.sv
module test_serial_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] baud_div = 8'd2;
    logic       sync_en = 1'b1, fast_en = 1'b0, xclk_dir_out = 1'b1, xclk_in = 1'b0;
    logic       xclk_out, xclk_oe, tx_tick, rx_tick, samp_rise, samp_fall;

    int total = 0, bad = 0;
    int q_rx[$], q_tx[$], q_rs[$], q_fs[$];
    int oe_hi, out_hi, out_bad;
    int cur_d;
    bit chk_master;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_clkgen i_serial_clkgen (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .sync_en(sync_en),
        .fast_en(fast_en), .xclk_dir_out(xclk_dir_out), .xclk_in(xclk_in),
        .xclk_out(xclk_out), .xclk_oe(xclk_oe), .tx_tick(tx_tick), .rx_tick(rx_tick),
        .samp_rise(samp_rise), .samp_fall(samp_fall)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare logged strobe cycles with an arithmetic series first+step*j <= win.
    task automatic check_series(input string tag, input int got[$],
                                input int first, input int step, input int win);
        int exp[$];
        bit ok = 1'b1;
        for (int t = first; t <= win; t += step) exp.push_back(t);
        total++;
        if (got.size() != exp.size()) ok = 1'b0;
        else for (int i = 0; i < exp.size(); i++) if (got[i] != exp[i]) ok = 1'b0;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual count=%0d first=%0d expected count=%0d first=%0d",
                     tag, got.size(), (got.size() > 0) ? got[0] : -1,
                     exp.size(), (exp.size() > 0) ? exp[0] : -1);
        end
    endtask

    // Step win cycles from the current negedge, logging strobes; optional stimulus.
    task automatic run_win(input int win, input int flip_dbl_at,
                           input int flip_dir_at, input int ext_p);
        q_rx.delete(); q_tx.delete(); q_rs.delete(); q_fs.delete();
        oe_hi = 0; out_hi = 0; out_bad = 0;
        xclk_in = 1'b0;
        for (int k = 1; k <= win; k++) begin
            @(negedge clk);
            if (rx_tick)   q_rx.push_back(k);
            if (tx_tick)   q_tx.push_back(k);
            if (samp_rise) q_rs.push_back(k);
            if (samp_fall) q_fs.push_back(k);
            if (xclk_oe)   oe_hi++;
            if (xclk_out)  out_hi++;
            if (chk_master && (xclk_out != (((k - 1) / (cur_d + 1)) % 2 == 1))) out_bad++;
            if (k == flip_dbl_at) fast_en = ~fast_en;
            if (k == flip_dir_at) xclk_dir_out = ~xclk_dir_out;
            xclk_in = (ext_p > 0) && ((k % ext_p) >= ext_p / 2);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int strobes;
        // R9: reset holds strobes and the transfer clock low.
        strobes = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            strobes += int'(tx_tick) + int'(rx_tick) + int'(samp_rise) + int'(samp_fall) + int'(xclk_out);
        end
        check_eq("R9 outputs quiet in reset", strobes, 0);

        // R9/R8: reset exit in master mode restarts, D=2.
        rst_n = 1'b1;
        cur_d = 2; chk_master = 1'b1;
        run_win(30, 0, 0, 0);
        check_series("R9 first master rise after reset", q_rs, 3, 6, 30);
        check_series("R9 first master fall after reset", q_fs, 6, 6, 30);

        for (int d = 0; d < 6; d++) begin
            if (d == 4) continue;
            cur_d = d;
            // Normal async (from master: restart). Flip pin direction mid-window (R7).
            chk_master = 1'b0;
            baud_div = 8'(d); sync_en = 1'b0; fast_en = 1'b0;
            run_win(32 * (d + 1) + 3, 0, 5, 4);
            check_series($sformatf("R1 base tick D=%0d", d), q_rx, d + 1, d + 1, 32 * (d + 1) + 3);
            check_series($sformatf("R2 normal bit tick D=%0d", d), q_tx, 16 * (d + 1), 16 * (d + 1), 32 * (d + 1) + 3);
            check_eq($sformatf("R7 no edge strobes async D=%0d", d), q_rs.size() + q_fs.size(), 0);
            check_eq($sformatf("R7 pin quiet async D=%0d", d), oe_hi + out_hi, 0);
            xclk_dir_out = 1'b1;
            // Double-speed async (restart R8).
            fast_en = 1'b1;
            run_win(24 * (d + 1) + 2, 0, 0, 0);
            check_series($sformatf("R3 fast bit tick D=%0d", d), q_tx, 8 * (d + 1), 8 * (d + 1), 24 * (d + 1) + 2);
            check_series($sformatf("R8 first base tick after change D=%0d", d), q_rx, d + 1, d + 1, 24 * (d + 1) + 2);
            // Master, flip fast_en mid-window (R4).
            sync_en = 1'b1; chk_master = 1'b1;
            run_win(8 * (d + 1) + 1, 4, 0, 0);
            check_series($sformatf("R5 master rise D=%0d", d), q_rs, d + 1, 2 * (d + 1), 8 * (d + 1) + 1);
            check_series($sformatf("R4 master fall unaffected by fast_en D=%0d", d), q_fs, 2 * (d + 1), 2 * (d + 1), 8 * (d + 1) + 1);
            check_series($sformatf("R5 master rx_tick D=%0d", d), q_rx, d + 1, 2 * (d + 1), 8 * (d + 1) + 1);
            check_series($sformatf("R5 master tx_tick D=%0d", d), q_tx, 2 * (d + 1), 2 * (d + 1), 8 * (d + 1) + 1);
            check_eq($sformatf("R5 master clock level D=%0d", d), out_bad, 0);
            check_eq($sformatf("R5 master oe D=%0d", d), oe_hi, 8 * (d + 1) + 1);
        end

        // Slave mode, external period 8 then 6.
        chk_master = 1'b0;
        fast_en = 1'b0; xclk_dir_out = 1'b0;
        run_win(40, 0, 0, 8);
        check_series("R6 slave rise P=8", q_rs, 6, 8, 40);
        check_series("R6 slave fall P=8", q_fs, 10, 8, 40);
        check_series("R6 slave rx_tick P=8", q_rx, 6, 8, 40);
        check_eq("R6 slave pin not driven", oe_hi + out_hi, 0);
        run_win(6, 0, 0, 0);
        run_win(36, 0, 0, 6);
        check_series("R6 slave rise P=6", q_rs, 5, 6, 36);
        check_series("R6 slave tx_tick P=6", q_tx, 8, 6, 36);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule